// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter

This block is a modulo-256 counter that takes two count strobes instead of a clock and a direction bit. A rising edge on the up strobe adds one, and a rising edge on the down strobe subtracts one. A strobe edge counts only while the other strobe rests high. One system clock samples both strobes through a synchroniser and detects their edges, so the whole block sits in a single clock domain. The strobes are asynchronous pulse sources, for example from a panel or another clock region.

The counter also has an asynchronous active-low clear and an asynchronous parallel load. It has a synchronous count enable and two active-low terminal-count flags. The up flag warns that the next upward step will overflow, and the down flag warns that the next downward step will underflow. The count width and the synchroniser depth are parameters. The default is an 8-bit count with a two-stage synchroniser.

Top module: `updown_strobe_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 at once, without any clock edge. Both flags read 1 from reset onward until a strobe is held low.
- R2: While `load` is high and `rst_n` is high, `count` takes `load_val` at once on the rising edge of `load`, without waiting for a clock edge, and holds it while `load` stays high.
- R3: A rising edge on `up_strb` while `dn_strb` is high increments `count` by one. The new value appears after the third rising `clk` edge following the strobe edge (two synchroniser stages plus the count register).
- R4: A rising edge on `dn_strb` while `up_strb` is high decrements `count` by one, with the same latency as R3.
- R5: Counting wraps modulo 256. Incrementing 255 gives 0, and decrementing 0 gives 255.
- R6: With `en` low, strobe edges leave `count` unchanged.
- R7: If rising edges of both strobes are detected in the same clock cycle, `count` is unchanged.
- R8: `tc_up_n` is 0 exactly when `count` is 255, the synchronised up strobe is low and the synchronised down strobe is high. Otherwise it is 1.
- R9: `tc_dn_n` is 0 exactly when `count` is 0, the synchronised down strobe is low and the synchronised up strobe is high. Otherwise it is 1.
- R10: A rising edge on one strobe while the other strobe is low does not change `count`.
- R11: While `load` is high, strobe edges do not change `count`. The loaded value is kept after `load` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| load | input | 1 | Asynchronous parallel load, active high |
| load_val | input | 8 | Value copied into the count on load |
| en | input | 1 | Synchronous count enable |
| up_strb | input | 1 | Count-up strobe, idles high |
| dn_strb | input | 1 | Count-down strobe, idles high |
| count | output | 8 | Current count value |
| tc_up_n | output | 1 | Terminal count on the way up, active low |
| tc_dn_n | output | 1 | Terminal count on the way down, active low |

## Verification
The detected up edge and the detected down edge can fall in the same cycle. The bench provokes this by pulling both strobes low on one falling clock edge and releasing them together. It then requires the count to stay where it was.

A second collision is a strobe edge that arrives while `load` is high, since both the asynchronous load and the count path target the count register. The bench judges that case by reading `count` after the strobe has fully propagated.

// File: rtl/ud_pkg.sv
package ud_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;
endpackage

// File: rtl/ud_edge_sync.sv
module ud_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strb,
    output logic level,
    output logic rise
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN-2:0], strb};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/ud_next_count.sv
module ud_next_count
    import ud_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             en,
    input  logic             up_rise,
    input  logic             dn_rise,
    input  logic             up_lvl,
    input  logic             dn_lvl,
    input  logic [WIDTH-1:0] count_q,
    output logic [WIDTH-1:0] count_d
);
    step_e step;

    always_comb begin
        step = STEP_HOLD;
        if (en) begin
            if (up_rise && !dn_rise && dn_lvl)      step = STEP_INC;
            else if (dn_rise && !up_rise && up_lvl) step = STEP_DEC;
        end
        case (step)
            STEP_INC: count_d = count_q + WIDTH'(1);
            STEP_DEC: count_d = count_q - WIDTH'(1);
            default:  count_d = count_q;
        endcase
    end
endmodule

// File: rtl/ud_term_flags.sv
module ud_term_flags #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] count_q,
    input  logic             up_lvl,
    input  logic             dn_lvl,
    output logic             tc_up_n,
    output logic             tc_dn_n
);
    localparam logic [WIDTH-1:0] TOP = '1;

    always_comb begin
        tc_up_n = !((count_q == TOP) && !up_lvl && dn_lvl);
        tc_dn_n = !((count_q == '0)  && !dn_lvl && up_lvl);
    end
endmodule

// File: rtl/updown_strobe_counter.sv
module updown_strobe_counter #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             en,
    input  logic             up_strb,
    input  logic             dn_strb,
    output logic [WIDTH-1:0] count,
    output logic             tc_up_n,
    output logic             tc_dn_n
);
    typedef struct packed {
        logic [WIDTH-1:0] count;
    } state_t;

    state_t state_d, state_q;
    logic   up_lvl, up_rise, dn_lvl, dn_rise;
    logic [WIDTH-1:0] next_count;

    ud_edge_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
        .clk(clk), .rst_n(rst_n), .strb(up_strb), .level(up_lvl), .rise(up_rise)
    );

    ud_edge_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
        .clk(clk), .rst_n(rst_n), .strb(dn_strb), .level(dn_lvl), .rise(dn_rise)
    );

    ud_next_count #(.WIDTH(WIDTH)) u_next (
        .en(en), .up_rise(up_rise), .dn_rise(dn_rise),
        .up_lvl(up_lvl), .dn_lvl(dn_lvl),
        .count_q(state_q.count), .count_d(next_count)
    );

    always_comb begin
        state_d       = state_q;
        state_d.count = next_count;
    end

    always_ff @(posedge clk or negedge rst_n or posedge load) begin
        if (!rst_n)    state_q       <= '0;
        else if (load) state_q.count <= load_val;
        else           state_q       <= state_d;
    end

    ud_term_flags #(.WIDTH(WIDTH)) u_flags (
        .count_q(state_q.count), .up_lvl(up_lvl), .dn_lvl(dn_lvl),
        .tc_up_n(tc_up_n), .tc_dn_n(tc_dn_n)
    );

    assign count = state_q.count;
endmodule

// File: rtl/ud_counter_checker.sv
module ud_counter_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic [WIDTH-1:0] load_val,
    input logic             en,
    input logic [WIDTH-1:0] count,
    input logic             up_rise,
    input logic             dn_rise,
    input logic             up_lvl,
    input logic             dn_lvl,
    input logic             tc_up_n,
    input logic             tc_dn_n
);
    // R2: a held load keeps the count equal to a stable load value
    a_r2_load_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (load && $past(load) && $past(rst_n) && $stable(load_val)) |-> count == load_val);

    // R3, R5: a qualified up edge advances the count by one, modulo 2^WIDTH
    a_r3_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && en && up_rise && !dn_rise && dn_lvl)
        |=> (load || count == WIDTH'($past(count) + WIDTH'(1))));

    // R4, R5: a qualified down edge retreats the count by one
    a_r4_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && en && dn_rise && !up_rise && up_lvl)
        |=> (load || count == WIDTH'($past(count) - WIDTH'(1))));

    // R6: disabled counting holds the value
    a_r6_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !en) |=> (load || count == $past(count)));

    // R7: simultaneous edges hold the value
    a_r7_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && up_rise && dn_rise) |=> (load || count == $past(count)));

    // R8: up flag only at the top value with the up strobe low
    a_r8_up_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !tc_up_n |-> (count == '1 && !up_lvl));

    // R9: down flag only at zero with the down strobe low
    a_r9_dn_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !tc_dn_n |-> (count == '0 && !dn_lvl));
endmodule

bind updown_strobe_counter ud_counter_checker #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .en(en),
    .count(count), .up_rise(up_rise), .dn_rise(dn_rise),
    .up_lvl(up_lvl), .dn_lvl(dn_lvl), .tc_up_n(tc_up_n), .tc_dn_n(tc_dn_n)
);

// File: tb/tb_updown_strobe_counter.sv
`timescale 1ns/1ps
module tb_updown_strobe_counter;
    logic       clk = 1'b0;
    logic       rst_n, load, en, up_strb, dn_strb;
    logic [7:0] load_val;
    logic [7:0] count;
    logic       tc_up_n, tc_dn_n;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2.5 clk = ~clk;

    updown_strobe_counter dut (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .en(en),
        .up_strb(up_strb), .dn_strb(dn_strb), .count(count),
        .tc_up_n(tc_up_n), .tc_dn_n(tc_dn_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_load(input logic [7:0] v);
        @(negedge clk);
        load_val = v;
        load = 1'b1;
        wait_neg(1);
        load = 1'b0;
        wait_neg(1);
    endtask

    task automatic pulse_up();
        @(negedge clk); up_strb = 1'b0;
        wait_neg(4);    up_strb = 1'b1;
        wait_neg(5);
    endtask

    task automatic pulse_dn();
        @(negedge clk); dn_strb = 1'b0;
        wait_neg(4);    dn_strb = 1'b1;
        wait_neg(5);
    endtask

    task automatic t_reset_state();
        #12;
        chk("R1 count in reset", count, 0);
        chk("R1 tc_up_n in reset", tc_up_n, 1);
        chk("R1 tc_dn_n in reset", tc_dn_n, 1);
        @(negedge clk); rst_n = 1'b1;
        wait_neg(2);
    endtask

    task automatic t_count_up();
        do_load(8'd10);
        for (int k = 0; k < 3; k++) pulse_up();
        chk("R3 three up edges", count, 13);
    endtask

    task automatic t_latency();
        do_load(8'd20);
        @(negedge clk); up_strb = 1'b0;
        wait_neg(3);
        @(negedge clk); up_strb = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        chk("R3 no change after two edges", count, 20);
        @(posedge clk); #1;
        chk("R3 change after third edge", count, 21);
        wait_neg(3);
    endtask

    task automatic t_count_down();
        do_load(8'd13);
        pulse_dn();
        pulse_dn();
        chk("R4 two down edges", count, 11);
    endtask

    task automatic t_enable();
        do_load(8'd11);
        en = 1'b0;
        pulse_up();
        chk("R6 up edge with enable low", count, 11);
        pulse_dn();
        chk("R6 down edge with enable low", count, 11);
        en = 1'b1;
    endtask

    task automatic t_wrap_up();
        do_load(8'd255);
        @(negedge clk); up_strb = 1'b0;
        wait_neg(3);
        chk("R8 tc_up_n at 255 going up", tc_up_n, 0);
        chk("R9 tc_dn_n at 255 going up", tc_dn_n, 1);
        up_strb = 1'b1;
        wait_neg(5);
        chk("R5 wrap 255 to 0", count, 0);
        chk("R8 tc_up_n released", tc_up_n, 1);
    endtask

    task automatic t_wrap_dn();
        do_load(8'd0);
        @(negedge clk); dn_strb = 1'b0;
        wait_neg(3);
        chk("R9 tc_dn_n at 0 going down", tc_dn_n, 0);
        chk("R8 tc_up_n at 0 going down", tc_up_n, 1);
        dn_strb = 1'b1;
        wait_neg(5);
        chk("R5 wrap 0 to 255", count, 255);
        chk("R9 tc_dn_n released", tc_dn_n, 1);
    endtask

    task automatic t_both_edges();
        do_load(8'd50);
        @(negedge clk); up_strb = 1'b0; dn_strb = 1'b0;
        wait_neg(4);    up_strb = 1'b1; dn_strb = 1'b1;
        wait_neg(5);
        chk("R7 simultaneous edges hold", count, 50);
    endtask

    task automatic t_other_low();
        do_load(8'd255);
        @(negedge clk); up_strb = 1'b0;
        wait_neg(2);    dn_strb = 1'b0;
        wait_neg(3);
        chk("R8 both strobes low keeps tc_up_n high", tc_up_n, 1);
        up_strb = 1'b1;
        wait_neg(5);
        chk("R10 up edge while down low ignored", count, 255);
        dn_strb = 1'b1;
        wait_neg(5);
        chk("R4 down edge with up high", count, 254);
    endtask

    task automatic t_async_load();
        @(negedge clk);
        load_val = 8'hA5;
        load = 1'b1;
        #1;
        chk("R2 load without clock edge", count, 8'hA5);
        pulse_up();
        chk("R11 up edge during load", count, 8'hA5);
        load = 1'b0;
        wait_neg(2);
        chk("R11 value kept after load", count, 8'hA5);
    endtask

    task automatic t_async_reset();
        do_load(8'd77);
        @(negedge clk); rst_n = 1'b0;
        #1;
        chk("R1 clear without clock edge", count, 0);
        @(negedge clk); rst_n = 1'b1;
        wait_neg(2);
        chk("R1 count after clear release", count, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; load = 1'b0; load_val = '0;
        en = 1'b1; up_strb = 1'b1; dn_strb = 1'b1;
        t_reset_state();
        t_count_up();
        t_latency();
        t_count_down();
        t_enable();
        t_wrap_up();
        t_wrap_dn();
        t_both_edges();
        t_other_low();
        t_async_load();
        t_async_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule